// File: doc/BRIEF.md
# Oscillator Frequency Setting Calculator

This block turns a requested output frequency in Hz into the three settings of a fractional-N oscillator. The settings are a power-of-two low-speed divider exponent, an even high-speed divider, and a multiplier. The multiplier is a fixed-point value with 29 fractional bits, taken relative to a 31.98 MHz reference. The VCO must stay at or above 2.08 GHz, and the high-speed divider is limited to 1022 during the exponent search.

A one-cycle start pulse captures the 32-bit frequency. A request outside the supported range is answered on the next cycle with the invalid flag and all-zero settings. A valid request runs through three steps: an iterative exponent search, a 32-step restoring division for the high-speed divider, and a 64-step restoring division for the multiplier. When the results are ready, a single done pulse is raised. The results then stay on the outputs until the next completed request.

Top module: `osc_muldiv_calc`

## Requirements
- R1: A start with a frequency below 100000 or above 250000000 gives, in the next cycle, done_o=1 and invalid_o=1, with ls_exp_o, hs_div_o, m_int_o and m_frac_o all zero. busy_o never rises for such a request. The values 100000 and 250000000 are accepted.
- R2: For a frequency of at least 2035225 (2080000000/1022 rounded down), ls_exp_o is 0.
- R3: For a lower frequency, ls_exp_o is the smallest e in 1..5 for which frequency × 1022 × 2^e ≥ 2080000000.
- R4: hs_div_o equals 2 × ceil(1040000000 / S), where S = frequency << ls_exp_o. hs_div_o is 11 bits wide, so the value 1024 can be represented.
- R5: The multiplier is M = floor(((S × hs_div_o) × 2^29 + 15990000) / 31980000). m_frac_o holds M bits 28:0 and m_int_o holds M bits 36:29.
- R6: busy_o is high from the cycle after an accepted in-range start until the done cycle. In the cycle where done_o is high, busy_o is low.
- R7: The four settings outputs and invalid_o change only in a cycle where done_o is high.
- R8: A start that arrives while busy_o is high is ignored. The request in progress completes with its own results, and only one done pulse is produced.
- R9: A valid result clears an invalid_o that was set by an earlier rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; sampled only while idle |
| freq_i | input | 32 | Requested frequency in Hz |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result pulse |
| invalid_o | output | 1 | Last request was out of range |
| ls_exp_o | output | 3 | Low-speed divider exponent |
| hs_div_o | output | 11 | High-speed divider (even) |
| m_int_o | output | 8 | Multiplier integer part |
| m_frac_o | output | 29 | Multiplier fraction, 29 bits |

## Verification
The bench applies frequencies on both sides of each range limit and on both sides of the exponent-zero threshold, 2035225 and 2035224. This shows whether the range gate and the threshold are inclusive and whether the search starts at exponent 1. The lowest legal frequency drives the search to its deepest step. Mid-band values such as 10 MHz, 1 MHz and 500 kHz stop the search at intermediate exponents, and odd values like 33333333 and 148500000 exercise the ceiling and rounding terms in both divisions. A second start issued while busy, and a rejected request followed by a valid one, separate correct request capture from state that leaks between requests.

// File: rtl/osc_calc_pkg.sv
package osc_calc_pkg;
  localparam int unsigned REF_HZ     = 31980000;
  localparam int unsigned VCO_MIN_HZ = 2080000000;
  localparam int unsigned HS_LIMIT   = 1022;
  localparam int unsigned FREQ_MIN   = 100000;
  localparam int unsigned FREQ_MAX   = 250000000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_HS_GO,
    ST_HS_RUN,
    ST_M_GO,
    ST_M_RUN
  } calc_st_e;
endpackage

// File: rtl/osc_seq_div.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles after start_i.
module osc_seq_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    ge    = trial >= {1'b0, den_q};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        den_q <= den_i;
        quo_q <= num_i;
        cnt_q <= CNT_W'(NUM_W);
      end else if (cnt_q != '0) begin
        quo_q <= {quo_q[NUM_W-2:0], ge};
        rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done_o <= 1'b1;
      end
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/osc_ls_search.sv
// Smallest power-of-two low-speed exponent that lifts the VCO to its floor.
module osc_ls_search
  import osc_calc_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int EXP_W   = 3,
  parameter int EXP_CAP = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic              fin_o
);
  localparam int TRIAL_W = FREQ_W + 16;
  localparam logic [FREQ_W-1:0]  THRESH = FREQ_W'(VCO_MIN_HZ / HS_LIMIT);
  localparam logic [TRIAL_W-1:0] VCO_T  = TRIAL_W'(VCO_MIN_HZ);
  localparam logic [TRIAL_W-1:0] FACT0  = TRIAL_W'(2 * HS_LIMIT);

  logic [TRIAL_W-1:0] trial_q;
  logic [EXP_W-1:0]   exp_q;
  logic               fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q <= '0;
      exp_q   <= '0;
      fin_q   <= 1'b0;
    end else if (load_i) begin
      if (freq_i >= THRESH) begin
        exp_q <= '0;
        fin_q <= 1'b1;
      end else begin
        exp_q   <= EXP_W'(1);
        trial_q <= TRIAL_W'(freq_i) * FACT0;
        fin_q   <= 1'b0;
      end
    end else if (!fin_q) begin
      if (trial_q >= VCO_T || exp_q == EXP_W'(EXP_CAP)) begin
        fin_q <= 1'b1;
      end else begin
        trial_q <= trial_q << 1;
        exp_q   <= exp_q + 1'b1;
      end
    end
  end

  assign exp_o = exp_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/osc_muldiv_calc.sv
module osc_muldiv_calc
  import osc_calc_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int EXP_W   = 3,
  parameter int EXP_CAP = 5,
  parameter int HS_W    = 11,
  parameter int MINT_W  = 8,
  parameter int FRAC_W  = 29,
  parameter int MDIV_W  = 64,
  parameter int REF_W   = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       freq_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              invalid_o,
  output logic [2:0]        ls_exp_o,
  output logic [10:0]       hs_div_o,
  output logic [7:0]        m_int_o,
  output logic [28:0]       m_frac_o
);
  localparam int PROD_W = FREQ_W + HS_W;
  localparam logic [FREQ_W-1:0] HALF_VCO = FREQ_W'(VCO_MIN_HZ / 2);
  localparam logic [MDIV_W-1:0] ROUND_T  = MDIV_W'(REF_HZ / 2);
  localparam logic [REF_W-1:0]  REF_DEN  = REF_W'(REF_HZ);

  calc_st_e          st_q;
  logic [FREQ_W-1:0] freq_q;
  logic [HS_W-1:0]   hs_q;
  logic [EXP_W-1:0]  exp_w;
  logic              fin_w, load_w, in_range;
  logic [FREQ_W-1:0] scaled, hs_num, hs_quo;
  logic              hs_done, m_done;
  logic [PROD_W-1:0] prod;
  logic [MDIV_W-1:0] m_num, m_quo;

  assign in_range = (freq_i >= FREQ_W'(FREQ_MIN)) && (freq_i <= FREQ_W'(FREQ_MAX));
  assign load_w   = (st_q == ST_IDLE) && start_i && in_range;
  assign scaled   = freq_q << exp_w;
  assign hs_num   = HALF_VCO + scaled - 1'b1;
  assign prod     = PROD_W'(scaled) * PROD_W'(hs_q);
  assign m_num    = (MDIV_W'(prod) << FRAC_W) + ROUND_T;

  osc_ls_search #(.FREQ_W(FREQ_W), .EXP_W(EXP_W), .EXP_CAP(EXP_CAP)) i_search (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .freq_i (freq_i),
    .exp_o  (exp_w),
    .fin_o  (fin_w)
  );

  osc_seq_div #(.NUM_W(FREQ_W), .DEN_W(FREQ_W)) i_hs_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (st_q == ST_HS_GO),
    .num_i   (hs_num),
    .den_i   (scaled),
    .done_o  (hs_done),
    .quo_o   (hs_quo)
  );

  osc_seq_div #(.NUM_W(MDIV_W), .DEN_W(REF_W)) i_m_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (st_q == ST_M_GO),
    .num_i   (m_num),
    .den_i   (REF_DEN),
    .done_o  (m_done),
    .quo_o   (m_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      freq_q    <= '0;
      hs_q      <= '0;
      done_o    <= 1'b0;
      invalid_o <= 1'b0;
      ls_exp_o  <= '0;
      hs_div_o  <= '0;
      m_int_o   <= '0;
      m_frac_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (in_range) begin
            freq_q <= freq_i;
            st_q   <= ST_SEARCH;
          end else begin
            done_o    <= 1'b1;
            invalid_o <= 1'b1;
            ls_exp_o  <= '0;
            hs_div_o  <= '0;
            m_int_o   <= '0;
            m_frac_o  <= '0;
          end
        end
        ST_SEARCH: if (fin_w) st_q <= ST_HS_GO;
        ST_HS_GO:  st_q <= ST_HS_RUN;
        ST_HS_RUN: if (hs_done) begin
          hs_q <= {hs_quo[HS_W-2:0], 1'b0};
          st_q <= ST_M_GO;
        end
        ST_M_GO:   st_q <= ST_M_RUN;
        ST_M_RUN:  if (m_done) begin
          ls_exp_o  <= exp_w;
          hs_div_o  <= hs_q;
          m_frac_o  <= m_quo[FRAC_W-1:0];
          m_int_o   <= m_quo[FRAC_W+MINT_W-1:FRAC_W];
          invalid_o <= 1'b0;
          done_o    <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  logic unused_bits;
  assign unused_bits = ^{hs_quo[FREQ_W-1:HS_W-1], m_quo[MDIV_W-1:FRAC_W+MINT_W]};
endmodule

// File: rtl/osc_calc_chk.sv
module osc_calc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [31:0] freq_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        invalid_o,
  input logic [2:0]  ls_exp_o,
  input logic [10:0] hs_div_o,
  input logic [7:0]  m_int_o,
  input logic [28:0] m_frac_o
);
  logic req_ok;
  assign req_ok = (freq_i >= 32'd100000) && (freq_i <= 32'd250000000);

  // R1
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !req_ok) |=> (done_o && invalid_o && !busy_o &&
      ls_exp_o == 3'd0 && hs_div_o == 11'd0 && m_int_o == 8'd0 && m_frac_o == 29'd0));

  // R6
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && req_ok) |=> busy_o);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({invalid_o, ls_exp_o, hs_div_o, m_int_o, m_frac_o}));

  // R8
  busy_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  // R3
  exp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !invalid_o) |-> (ls_exp_o <= 3'd5 && hs_div_o >= 11'd10));
endmodule

bind osc_muldiv_calc osc_calc_chk i_osc_calc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .freq_i    (freq_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .invalid_o (invalid_o),
  .ls_exp_o  (ls_exp_o),
  .hs_div_o  (hs_div_o),
  .m_int_o   (m_int_o),
  .m_frac_o  (m_frac_o)
);

// File: tb/test_osc_muldiv_calc.sv
module test_osc_muldiv_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] freq = '0;
  logic        busy, done, invalid;
  logic [2:0]  ls_exp;
  logic [10:0] hs_div;
  logic [7:0]  m_int;
  logic [28:0] m_frac;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;

  typedef struct {
    logic        inv;
    logic [2:0]  e;
    logic [10:0] hs;
    logic [7:0]  mi;
    logic [28:0] mf;
  } res_t;

  res_t sb_q[$];
  res_t last_res;

  always #2 clk = ~clk;

  osc_muldiv_calc i_osc_muldiv_calc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_i(freq),
    .busy_o(busy), .done_o(done), .invalid_o(invalid),
    .ls_exp_o(ls_exp), .hs_div_o(hs_div), .m_int_o(m_int), .m_frac_o(m_frac)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic res_t model(input longint unsigned f);
    res_t r;
    longint unsigned trial, s, q, hs, m;
    int e;
    r = '{default: '0};
    if (f < 100000 || f > 250000000) begin
      r.inv = 1'b1;
      return r;
    end
    if (f >= 64'd2080000000 / 64'd1022) e = 0;  // R2
    else begin                                   // R3
      e = 1;
      trial = f * 2044;
      while (trial < 64'd2080000000 && e < 5) begin
        trial = trial << 1;
        e++;
      end
    end
    s  = f << e;
    q  = (64'd1040000000 + s - 1) / s;           // R4
    hs = 2 * q;
    m  = (((s * hs) << 29) + 64'd15990000) / 64'd31980000;  // R5
    r.e  = 3'(e);
    r.hs = 11'(hs);
    r.mi = 8'(m >> 29);
    r.mf = 29'(m);
    return r;
  endfunction

  task automatic cmp(input res_t x, input string req);
    chk(invalid == x.inv, req, "invalid", longint'(invalid), longint'(x.inv));
    chk(ls_exp == x.e, req, "ls_exp", longint'(ls_exp), longint'(x.e));
    chk(hs_div == x.hs, req, "hs_div", longint'(hs_div), longint'(x.hs));
    chk(m_int == x.mi, req, "m_int", longint'(m_int), longint'(x.mi));
    chk(m_frac == x.mf, req, "m_frac", longint'(m_frac), longint'(x.mf));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      res_t x;
      n_done++;
      chk(!busy, "R6", "busy at done", longint'(busy), 0);
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected done", 1, 0);
      end else begin
        x = sb_q.pop_front();
        cmp(x, "R1-5/R9");
        last_res = x;
      end
    end
  end

  task automatic pulse(input logic [31:0] f);
    @(negedge clk);
    freq  = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drive(input logic [31:0] f, input string req);
    res_t x;
    x = model(longint'(f));
    sb_q.push_back(x);
    pulse(f);
    if (!x.inv) chk(busy == 1'b1, req, "busy after start (R6)", longint'(busy), 1);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // reset state
    chk(!busy && !done && !invalid, "R6", "reset flags", longint'({busy, done, invalid}), 0);
    chk(hs_div == 0 && m_int == 0 && m_frac == 0 && ls_exp == 0, "R7", "reset settings",
        longint'(hs_div), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    drive(32'd99999, "R1");
    drive(32'd100000, "R1");
    drive(32'd250000000, "R1");
    drive(32'd250000001, "R1");
    drive(32'd0, "R1");
    drive(32'd2035225, "R2");
    drive(32'd2035224, "R3");
    drive(32'd156250000, "R2");
    drive(32'd148500000, "R5");
    drive(32'd33333333, "R4");
    drive(32'd10000000, "R3");
    drive(32'd1000000, "R3");
    drive(32'd500000, "R3");
    drive(32'd150000, "R3");

    // R9: rejected request followed by a valid one
    drive(32'd50, "R9");
    drive(32'd125000000, "R9");

    // R7: outputs hold while idle and unchanged inputs wiggle
    freq = 32'd777;
    repeat (20) @(negedge clk);
    cmp(last_res, "R7");

    // R8: second start while busy is ignored
    begin
      res_t x;
      x = model(64'd24000000);
      sb_q.push_back(x);
      d0 = n_done;
      pulse(32'd24000000);
      repeat (5) @(negedge clk);
      pulse(32'd99999);
      chk(busy == 1'b1, "R8", "busy after ignored start", longint'(busy), 1);
      while (sb_q.size() != 0) @(negedge clk);
      repeat (150) @(negedge clk);
      chk(n_done == d0 + 1, "R8", "done count", longint'(n_done - d0), 1);
      cmp(x, "R8");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule